// File: doc/BRIEF.md
# Burst-Grouping DRAM Request Scheduler

This block orders read and write requests for one DRAM rank. Every accepted request sits in one shared pool of entries, whatever its direction. Requests that name the same bank and row form a burst. A burst takes its age from the moment its first access arrived. A request whose bank and row match nothing pending opens a fresh burst, stamped with the current value of a free-running arrival counter.

Each bank has its own arbiter. When that bank's timing-ok input is high, the arbiter nominates one pending entry. A channel selector then picks one nomination and drives it onto the command port on the following cycle. Normally the oldest burst wins. A burst that has grown long outranks any short burst, even an older one. Inside a burst, all reads leave before any write, and writes leave in arrival order.

A read that targets the exact address (bank, row, column) of a pending write never enters the pool. Its tag and the newest matching write data come back on the response port one cycle later. Timing counters, refresh and address mapping belong to the surrounding controller.

Top module: `burst_dram_sched`

## Requirements
- R1: `req_ready` is low exactly when the pool holds 8 entries. A request is taken only in a cycle where `req_valid` and `req_ready` are both high.
- R2: A taken request whose bank and row equal those of a pending entry joins that burst and inherits its age. Any other taken request opens a new burst aged by its own arrival.
- R3: Among eligible entries, an entry whose burst holds 3 or more pending entries (a long burst) beats an entry of a short burst. Within the same class, the older burst wins. Ages compare correctly across wraparound of the arrival counter.
- R4: Within one burst, every pending read issues before any write. Entries of the same direction issue in arrival order.
- R5: An entry is eligible only if `timing_ok[bank]` is high in the decision cycle. The chosen command appears on `cmd_*` with `cmd_valid` high in the next cycle. At most one command is issued per cycle, and `cmd_valid` stays low when nothing is eligible.
- R6: A taken read (`req_wr`=0) whose bank, row and column match a pending write is forwarded. In the next cycle `rsp_valid` is high, `rsp_tag` carries the read's tag and `rsp_data` carries the data of the newest such write. The read takes no pool entry and is never issued as a command.
- R7: Every taken, non-forwarded request is issued exactly once. Its direction, bank, row, column, data and tag are unchanged (`cmd_wr`=1 means write).
- R8: After reset the pool is empty, `req_ready` is high, and `cmd_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Pool can take a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 8 | Target row |
| req_col | input | 6 | Target column |
| req_data | input | 16 | Write data |
| req_tag | input | 4 | Requester tag |
| timing_ok | input | 4 | Per-bank: issuing now breaks no timing rule |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_wr | output | 1 | Issued command is a write |
| cmd_bank | output | 2 | Issued bank |
| cmd_row | output | 8 | Issued row |
| cmd_col | output | 6 | Issued column |
| cmd_data | output | 16 | Issued write data |
| cmd_tag | output | 4 | Issued tag |
| rsp_valid | output | 1 | Forwarded read response |
| rsp_tag | output | 4 | Tag of the forwarded read |
| rsp_data | output | 16 | Forwarded data |

## Verification
Some properties are checked on every cycle. The checker keeps an occupancy count built only from port traffic. From it, it confirms that the ready signal tracks a full pool and that the count never runs outside its range. It also confirms that each issued command names a bank whose timing-ok was high one cycle earlier, and that each response follows one cycle after a taken read and carries that read's tag.

The order of issue cannot be seen from any single cycle. This covers long-beats-short, oldest burst first, reads before writes, and which write a forward takes its data from. These are shown only by the bench's directed scenarios and by its reference queue, which predicts every output on every clock across thousands of random cycles, including arrival-counter wraparound.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
    localparam int unsigned NUM_ENT  = 8;
    localparam int unsigned NUM_BANK = 4;
    localparam int unsigned ROW_W    = 8;
    localparam int unsigned COL_W    = 6;
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned TAG_W    = 4;
    localparam int unsigned STAMP_W  = 8;
    localparam int unsigned LONG_LEN = 3;

    localparam int unsigned BANK_W = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
    localparam int unsigned IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    typedef struct packed {
        logic               vld;
        logic               wr;
        logic [BANK_W-1:0]  bank;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [DATA_W-1:0]  data;
        logic [TAG_W-1:0]   tag;
        logic [STAMP_W-1:0] bstamp;
        logic [STAMP_W-1:0] seq;
    } ent_t;

    typedef ent_t [NUM_ENT-1:0] pool_t;

    // ordering key of one entry, compared by rank_beats
    typedef struct packed {
        logic               lng;
        logic [STAMP_W-1:0] bstamp;
        logic               wr;
        logic [STAMP_W-1:0] seq;
    } rank_t;

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        rank_t             rk;
    } key_t;

    typedef key_t [NUM_ENT-1:0] keys_t;

    // a is older than b when (a - b) wraps negative
    function automatic logic stamp_older(input logic [STAMP_W-1:0] a,
                                         input logic [STAMP_W-1:0] b);
        logic [STAMP_W-1:0] diff;
        diff = a - b;
        return diff[STAMP_W-1];
    endfunction

    function automatic logic rank_beats(input rank_t a, input rank_t b);
        if (a.lng != b.lng)       return a.lng;
        if (a.bstamp != b.bstamp) return stamp_older(a.bstamp, b.bstamp);
        if (a.wr != b.wr)         return !a.wr;
        return stamp_older(a.seq, b.seq);
    endfunction
endpackage

// File: rtl/bsched_bank_arb.sv
module bsched_bank_arb
    import bsched_pkg::*;
#(
    parameter int unsigned BANK_ID = 0
) (
    input  keys_t             keys,
    input  logic              tok,
    output logic              nom_vld,
    output logic [IDX_W-1:0]  nom_idx
);
    logic             found;
    logic [IDX_W-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (tok && keys[i].vld && keys[i].bank == BANK_W'(BANK_ID)) begin
                if (!found || rank_beats(keys[i].rk, keys[best].rk)) begin
                    found = 1'b1;
                    best  = IDX_W'(i);
                end
            end
        end
        nom_vld = found;
        nom_idx = best;
    end
endmodule

// File: rtl/bsched_chan_sel.sv
module bsched_chan_sel
    import bsched_pkg::*;
(
    input  logic [NUM_BANK-1:0]  nom_vld,
    input  rank_t [NUM_BANK-1:0] nom_rk,
    output logic                 gnt_vld,
    output logic [BANK_W-1:0]    gnt_bank
);
    logic              found;
    logic [BANK_W-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '0;
        for (int b = 0; b < NUM_BANK; b++) begin
            if (nom_vld[b]) begin
                if (!found || rank_beats(nom_rk[b], nom_rk[best])) begin
                    found = 1'b1;
                    best  = BANK_W'(b);
                end
            end
        end
        gnt_vld  = found;
        gnt_bank = best;
    end
endmodule

// File: rtl/burst_dram_sched.sv
module burst_dram_sched
    import bsched_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_wr,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]    req_row,
    input  logic [COL_W-1:0]    req_col,
    input  logic [DATA_W-1:0]   req_data,
    input  logic [TAG_W-1:0]    req_tag,
    input  logic [NUM_BANK-1:0] timing_ok,
    output logic                cmd_valid,
    output logic                cmd_wr,
    output logic [BANK_W-1:0]   cmd_bank,
    output logic [ROW_W-1:0]    cmd_row,
    output logic [COL_W-1:0]    cmd_col,
    output logic [DATA_W-1:0]   cmd_data,
    output logic [TAG_W-1:0]    cmd_tag,
    output logic                rsp_valid,
    output logic [TAG_W-1:0]    rsp_tag,
    output logic [DATA_W-1:0]   rsp_data
);
    typedef struct packed {
        pool_t              pool;
        logic [STAMP_W-1:0] stamp;
        logic               cmd_vld;
        logic               cmd_wr;
        logic [BANK_W-1:0]  cmd_bank;
        logic [ROW_W-1:0]   cmd_row;
        logic [COL_W-1:0]   cmd_col;
        logic [DATA_W-1:0]  cmd_data;
        logic [TAG_W-1:0]   cmd_tag;
        logic               rsp_vld;
        logic [TAG_W-1:0]   rsp_tag;
        logic [DATA_W-1:0]  rsp_data;
    } st_t;

    st_t st_q, st_d;

    keys_t                          keys;
    logic [NUM_ENT-1:0]             long_v;
    logic                           full;
    logic [IDX_W-1:0]               free_idx;
    logic                           fwd_hit;
    logic [DATA_W-1:0]              fwd_data;
    logic [STAMP_W-1:0]             fwd_seq;
    logic                           join_hit;
    logic [STAMP_W-1:0]             join_stamp;
    logic [NUM_BANK-1:0]            nom_vld;
    logic [NUM_BANK-1:0][IDX_W-1:0] nom_idx;
    rank_t [NUM_BANK-1:0]           nom_rk;
    logic                           gnt_vld;
    logic [BANK_W-1:0]              gnt_bank;
    logic [IDX_W-1:0]               gnt_idx;

    // pool observation: burst lengths, keys, free slot, join and forward lookups
    always_comb begin
        int unsigned cnt;
        full       = 1'b1;
        free_idx   = '0;
        fwd_hit    = 1'b0;
        fwd_data   = '0;
        fwd_seq    = '0;
        join_hit   = 1'b0;
        join_stamp = st_q.stamp;
        for (int i = 0; i < NUM_ENT; i++) begin
            cnt = 0;
            for (int j = 0; j < NUM_ENT; j++) begin
                if (st_q.pool[i].vld && st_q.pool[j].vld &&
                    st_q.pool[i].bank == st_q.pool[j].bank &&
                    st_q.pool[i].row == st_q.pool[j].row)
                    cnt++;
            end
            long_v[i]         = (cnt >= LONG_LEN);
            keys[i].vld       = st_q.pool[i].vld;
            keys[i].bank      = st_q.pool[i].bank;
            keys[i].rk.lng    = long_v[i];
            keys[i].rk.bstamp = st_q.pool[i].bstamp;
            keys[i].rk.wr     = st_q.pool[i].wr;
            keys[i].rk.seq    = st_q.pool[i].seq;
        end
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!st_q.pool[i].vld) begin
                full     = 1'b0;
                free_idx = IDX_W'(i);
            end
        end
        for (int i = 0; i < NUM_ENT; i++) begin
            if (st_q.pool[i].vld && st_q.pool[i].bank == req_bank &&
                st_q.pool[i].row == req_row) begin
                if (!join_hit) join_stamp = st_q.pool[i].bstamp;
                join_hit = 1'b1;
                if (st_q.pool[i].wr && st_q.pool[i].col == req_col &&
                    (!fwd_hit || stamp_older(fwd_seq, st_q.pool[i].seq))) begin
                    fwd_hit  = 1'b1;
                    fwd_seq  = st_q.pool[i].seq;
                    fwd_data = st_q.pool[i].data;
                end
            end
        end
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        bsched_bank_arb #(.BANK_ID(b)) i_arb (
            .keys    (keys),
            .tok     (timing_ok[b]),
            .nom_vld (nom_vld[b]),
            .nom_idx (nom_idx[b])
        );
        assign nom_rk[b] = keys[nom_idx[b]].rk;
    end

    bsched_chan_sel i_sel (
        .nom_vld  (nom_vld),
        .nom_rk   (nom_rk),
        .gnt_vld  (gnt_vld),
        .gnt_bank (gnt_bank)
    );

    assign gnt_idx   = nom_idx[gnt_bank];
    assign req_ready = !full;

    always_comb begin
        st_d         = st_q;
        st_d.cmd_vld = gnt_vld;
        if (gnt_vld) begin
            st_d.cmd_wr   = st_q.pool[gnt_idx].wr;
            st_d.cmd_bank = st_q.pool[gnt_idx].bank;
            st_d.cmd_row  = st_q.pool[gnt_idx].row;
            st_d.cmd_col  = st_q.pool[gnt_idx].col;
            st_d.cmd_data = st_q.pool[gnt_idx].data;
            st_d.cmd_tag  = st_q.pool[gnt_idx].tag;
            st_d.pool[gnt_idx].vld = 1'b0;
        end
        st_d.rsp_vld = 1'b0;
        if (req_valid && !full) begin
            if (!req_wr && fwd_hit) begin
                st_d.rsp_vld  = 1'b1;
                st_d.rsp_tag  = req_tag;
                st_d.rsp_data = fwd_data;
            end else begin
                st_d.pool[free_idx].vld    = 1'b1;
                st_d.pool[free_idx].wr     = req_wr;
                st_d.pool[free_idx].bank   = req_bank;
                st_d.pool[free_idx].row    = req_row;
                st_d.pool[free_idx].col    = req_col;
                st_d.pool[free_idx].data   = req_data;
                st_d.pool[free_idx].tag    = req_tag;
                st_d.pool[free_idx].bstamp = join_hit ? join_stamp : st_q.stamp;
                st_d.pool[free_idx].seq    = st_q.stamp;
                st_d.stamp                 = st_q.stamp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_valid = st_q.cmd_vld;
    assign cmd_wr    = st_q.cmd_wr;
    assign cmd_bank  = st_q.cmd_bank;
    assign cmd_row   = st_q.cmd_row;
    assign cmd_col   = st_q.cmd_col;
    assign cmd_data  = st_q.cmd_data;
    assign cmd_tag   = st_q.cmd_tag;
    assign rsp_valid = st_q.rsp_vld;
    assign rsp_tag   = st_q.rsp_tag;
    assign rsp_data  = st_q.rsp_data;
endmodule

// File: rtl/bsched_chk.sv
module bsched_chk
    import bsched_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_wr,
    input logic [TAG_W-1:0]    req_tag,
    input logic [NUM_BANK-1:0] timing_ok,
    input logic                cmd_valid,
    input logic [BANK_W-1:0]   cmd_bank,
    input logic                rsp_valid,
    input logic [TAG_W-1:0]    rsp_tag
);
    logic [NUM_BANK-1:0] tok_q;
    logic                acc_q;
    int                  occ_q;
    int                  occ_now;

    always_comb occ_now = occ_q + ((acc_q && !rsp_valid) ? 1 : 0) - (cmd_valid ? 1 : 0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tok_q <= '0;
            acc_q <= 1'b0;
            occ_q <= 0;
        end else begin
            tok_q <= timing_ok;
            acc_q <= req_valid && req_ready;
            occ_q <= occ_now;
        end
    end

    // R1
    ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == (occ_now < int'(NUM_ENT)));

    // R7
    occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_now >= 0 && occ_now <= int'(NUM_ENT));

    // R5
    cmd_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> tok_q[cmd_bank]);

    // R6
    rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_wr));

    // R6
    rsp_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_tag == $past(req_tag));
endmodule

bind burst_dram_sched bsched_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_wr    (req_wr),
    .req_tag   (req_tag),
    .timing_ok (timing_ok),
    .cmd_valid (cmd_valid),
    .cmd_bank  (cmd_bank),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag)
);

// File: tb/test_burst_dram_sched.sv
module test_burst_dram_sched;
    import bsched_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                rst_n;
    logic                req_valid, req_ready, req_wr;
    logic [BANK_W-1:0]   req_bank;
    logic [ROW_W-1:0]    req_row;
    logic [COL_W-1:0]    req_col;
    logic [DATA_W-1:0]   req_data;
    logic [TAG_W-1:0]    req_tag;
    logic [NUM_BANK-1:0] timing_ok;
    logic                cmd_valid, cmd_wr;
    logic [BANK_W-1:0]   cmd_bank;
    logic [ROW_W-1:0]    cmd_row;
    logic [COL_W-1:0]    cmd_col;
    logic [DATA_W-1:0]   cmd_data;
    logic [TAG_W-1:0]    cmd_tag;
    logic                rsp_valid;
    logic [TAG_W-1:0]    rsp_tag;
    logic [DATA_W-1:0]   rsp_data;

    burst_dram_sched i_burst_dram_sched (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_data(req_data), .req_tag(req_tag), .timing_ok(timing_ok),
        .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_data(cmd_data),
        .cmd_tag(cmd_tag), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .rsp_data(rsp_data)
    );

    typedef struct {
        bit wr; int bank; int row; int col; int data; int tag; int bst; int seq;
    } mi_t;

    mi_t mq[$];
    int  mseq;
    bit  e_cmd_v, e_rsp_v;
    mi_t e_cmd;
    int  e_rsp_tag, e_rsp_data;
    int  total, bad;
    int  tag_log[$];
    bit  seen_rsp_v;
    int  seen_rsp_tag, seen_rsp_data;
    bit  done;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int burst_len(int k);
        int n = 0;
        foreach (mq[j]) if (mq[j].bank == mq[k].bank && mq[j].row == mq[k].row) n++;
        return n;
    endfunction

    // compare outputs registered at the previous edge with the model prediction
    task automatic compare();
        chk(cmd_valid == e_cmd_v, "R5", "cmd_valid", int'(cmd_valid), int'(e_cmd_v));
        if (cmd_valid && e_cmd_v) begin
            chk(int'(cmd_tag) == e_cmd.tag, "R3", "cmd_tag order", int'(cmd_tag), e_cmd.tag);
            chk(cmd_wr == e_cmd.wr, "R4", "cmd_wr", int'(cmd_wr), int'(e_cmd.wr));
            chk(int'(cmd_bank) == e_cmd.bank && int'(cmd_row) == e_cmd.row &&
                int'(cmd_col) == e_cmd.col && int'(cmd_data) == e_cmd.data,
                "R7", "cmd fields", int'(cmd_data), e_cmd.data);
        end
        if (cmd_valid) tag_log.push_back(int'(cmd_tag));
        chk(rsp_valid == e_rsp_v, "R6", "rsp_valid", int'(rsp_valid), int'(e_rsp_v));
        if (rsp_valid && e_rsp_v) begin
            chk(int'(rsp_tag) == e_rsp_tag, "R6", "rsp_tag", int'(rsp_tag), e_rsp_tag);
            chk(int'(rsp_data) == e_rsp_data, "R6", "rsp_data", int'(rsp_data), e_rsp_data);
        end
        seen_rsp_v = rsp_valid; seen_rsp_tag = int'(rsp_tag); seen_rsp_data = int'(rsp_data);
    endtask

    task automatic model_step();
        bit rdy = (mq.size() < NUM_ENT);
        int best = -1; bit bl = 0;
        bit fhit = 0; int fseq = -1; int fdata = 0;
        bit jhit = 0; int jbst = 0;
        chk(req_ready == rdy, "R1", "req_ready", int'(req_ready), int'(rdy));
        foreach (mq[i]) begin
            if (timing_ok[mq[i].bank]) begin
                bit l = (burst_len(i) >= LONG_LEN);
                bit win;
                if (best < 0) win = 1;
                else if (l != bl) win = l;
                else if (mq[i].bst != mq[best].bst) win = mq[i].bst < mq[best].bst;
                else if (mq[i].wr != mq[best].wr) win = !mq[i].wr;
                else win = mq[i].seq < mq[best].seq;
                if (win) begin best = i; bl = l; end
            end
        end
        e_rsp_v = 0;
        if (req_valid && rdy) begin
            foreach (mq[i]) begin
                if (mq[i].bank == int'(req_bank) && mq[i].row == int'(req_row)) begin
                    if (!jhit) jbst = mq[i].bst;
                    jhit = 1;
                    if (mq[i].wr && mq[i].col == int'(req_col) && mq[i].seq > fseq) begin
                        fhit = 1; fseq = mq[i].seq; fdata = mq[i].data;
                    end
                end
            end
        end
        e_cmd_v = (best >= 0);
        if (e_cmd_v) begin
            e_cmd = mq[best];
            mq.delete(best);
        end
        if (req_valid && rdy) begin
            if (!req_wr && fhit) begin
                e_rsp_v = 1; e_rsp_tag = int'(req_tag); e_rsp_data = fdata;
            end else begin
                mi_t n;
                n.wr = req_wr; n.bank = int'(req_bank); n.row = int'(req_row);
                n.col = int'(req_col); n.data = int'(req_data); n.tag = int'(req_tag);
                n.seq = mseq; n.bst = jhit ? jbst : mseq;
                mseq++;
                mq.push_back(n);
            end
        end
    endtask

    // one clock: called at a negedge, returns at the next negedge
    task automatic cyc(bit v, bit wr, int b, int r, int c, int d, int t, logic [NUM_BANK-1:0] tok);
        compare();
        req_valid = v; req_wr = wr;
        req_bank = BANK_W'(b); req_row = ROW_W'(r); req_col = COL_W'(c);
        req_data = DATA_W'(d); req_tag = TAG_W'(t); timing_ok = tok;
        #1;
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(int n, logic [NUM_BANK-1:0] tok);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, tok);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_wr = 0; req_bank = '0; req_row = '0;
        req_col = '0; req_data = '0; req_tag = '0; timing_ok = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: reset state
        chk(req_ready == 1'b1, "R8", "ready after reset", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R8", "cmd_valid after reset", int'(cmd_valid), 0);
        chk(rsp_valid == 1'b0, "R8", "rsp_valid after reset", int'(rsp_valid), 0);

        // R2 R3 R4: long burst beats older short burst, reads first, writes in order
        tag_log.delete();
        cyc(1, 0, 1, 2, 0, 16'h0010, 1, 4'b0000);
        cyc(1, 1, 0, 1, 0, 16'h0020, 2, 4'b0000);
        cyc(1, 0, 0, 1, 1, 16'h0030, 3, 4'b0000);
        cyc(1, 1, 0, 1, 2, 16'h0040, 4, 4'b0000);
        cyc(1, 1, 0, 5, 0, 16'h0050, 5, 4'b0000);
        chk(tag_log.size() == 0, "R5", "no cmd while timing blocked", tag_log.size(), 0);
        idle(8, 4'b1111);
        chk(tag_log.size() == 5, "R7", "burst scenario count", tag_log.size(), 5);
        if (tag_log.size() == 5) begin
            chk(tag_log[0] == 3, "R3", "long burst first", tag_log[0], 3);
            chk(tag_log[1] == 1, "R3", "older short burst next", tag_log[1], 1);
            chk(tag_log[2] == 2, "R4", "older write after read", tag_log[2], 2);
            chk(tag_log[3] == 4, "R4", "newer write last in burst", tag_log[3], 4);
            chk(tag_log[4] == 5, "R2", "separate row opens own burst", tag_log[4], 5);
        end

        // R6: read hits two queued writes to one address
        tag_log.delete();
        cyc(1, 1, 2, 3, 4, 16'h0111, 6, 4'b0000);
        cyc(1, 1, 2, 3, 4, 16'h0222, 7, 4'b0000);
        cyc(1, 0, 2, 3, 4, 16'h0000, 8, 4'b0000);
        cyc(0, 0, 0, 0, 0, 0, 0, 4'b0000);
        chk(seen_rsp_v == 1, "R6", "forward rsp_valid", int'(seen_rsp_v), 1);
        chk(seen_rsp_tag == 8, "R6", "forward tag", seen_rsp_tag, 8);
        chk(seen_rsp_data == 16'h0222, "R6", "forward newest data", seen_rsp_data, 16'h0222);
        idle(6, 4'b1111);
        chk(tag_log.size() == 2, "R6", "forwarded read not issued", tag_log.size(), 2);

        // R1: fill the pool, ninth request stalls
        tag_log.delete();
        for (int k = 0; k < 8; k++) cyc(1, 1, 3, 10 + k, 0, k, k, 4'b0000);
        chk(req_ready == 1'b0, "R1", "ready low when full", int'(req_ready), 0);
        cyc(1, 1, 3, 40, 0, 99, 15, 4'b0000);
        cyc(0, 0, 0, 0, 0, 0, 0, 4'b0000);
        chk(req_ready == 1'b0, "R1", "stalled request not taken", int'(req_ready), 0);
        idle(12, 4'b1000);
        chk(tag_log.size() == 8, "R7", "each entry issued once", tag_log.size(), 8);

        // random traffic checked against the model on every clock (R3 wraparound)
        for (int k = 0; k < 6000; k++) begin
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 65535),
                $urandom_range(0, 15), NUM_BANK'($urandom_range(0, 15)));
        end
        idle(20, 4'b1111);
        chk(mq.size() == 0 && req_ready == 1'b1, "R7", "pool drained", int'(req_ready), 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule